// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block decides, in the same cycle as the access, whether an instruction or data address may be used. It also decides which cache attributes apply to it. Eight protection regions are held in registers. Each region has a base address, a size that is a power of two, an enable, a cacheable bit, a bufferable bit and a two-bit permission code. Every region compares the incoming address in parallel. When several enabled regions contain the address, the one with the highest index supplies the attributes and the permission. An address that no enabled region covers is refused.

The access side takes an address, an access kind (read, write or fetch) and a privilege flag. It returns cacheable, bufferable and abort through combinational logic. A register write port programs one region per cycle. A separate control write turns the whole unit on or off. While the unit is off, every access is allowed and is treated as non-cacheable and non-bufferable. A system normally has two instances: one checks the instruction side and one checks the data side, each with its own region set.

Top module: `prot_region_unit`

## Requirements
- R1: After reset every region is disabled and the unit is off, so no access aborts and cacheable and bufferable read 0.
- R2: While the unit is off, every access gets abort=0, cacheable=0 and bufferable=0, whatever the regions hold.
- R3: A region of size code s covers the 2^(s+12) bytes that start at its base address. Base bits below the region size are ignored. Size codes 0 to 20 give 4 KB to 4 GB, and any code above 20 acts as 20.
- R4: While the unit is on, an address that no enabled region covers aborts.
- R5: When several enabled regions cover an address, the region with the highest index decides the permission and the attributes.
- R6: The permission code is applied with fetch counted as a read. The codes are: 0 = no access for anyone; 1 = supervisor read/write, no user access; 2 = supervisor read/write, user read only; 3 = read/write for both. Access kind encoding: 0 = read, 1 = write, 2 = fetch, 3 = read.
- R7: An allowed access takes cacheable and bufferable from the winning region. An aborted access has both at 0.
- R8: A region write (index, base, size, enable, permission, attributes) or a control write changes the outputs from the cycle after the write edge and not before. Writing one region leaves the other regions unchanged. A disabled region takes no part in matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Write strobe for the unit on/off control |
| ctl_on | input | 1 | Control value: 1 turns the unit on |
| cfg_we | input | 1 | Write strobe for the region given by cfg_idx |
| cfg_idx | input | 3 | Index of the region to write |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code: the region spans 2^(code+12) bytes |
| cfg_en | input | 1 | Region enable |
| cfg_perm | input | 2 | Permission code |
| cfg_cache | input | 1 | Cacheable attribute |
| cfg_buf | input | 1 | Bufferable attribute |
| acc_addr | input | 32 | Address being checked |
| acc_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 read |
| acc_priv | input | 1 | 1 for a supervisor access, 0 for a user access |
| acc_abort | output | 1 | The access is refused |
| acc_cache | output | 1 | Cacheable attribute for the access |
| acc_buf | output | 1 | Bufferable attribute for the access |

## Verification
Each region is held in a few registers and the check path has no state of its own. A corrupted region field therefore shows on the ports within the same cycle, at the first address that reaches it. Examples: a wrong size or base bit moves the region edge, so an address just inside or just outside it gets the wrong abort; a wrong enable or index makes the wrong region win an overlap; a wrong permission bit lets through, or refuses, a user write or a supervisor read. The bench probes addresses on both sides of each region edge and both ways through an overlap. It also checks outputs one cycle before and one cycle after each write, so a write that lands a cycle early or late is seen.

// File: rtl/prot_region_unit.sv
module prot_region_unit #(
  parameter int AW     = 32,
  parameter int NREG   = 8,
  parameter int MINLOG = 12,
  localparam int IW    = $clog2(NREG),
  localparam int MAXC  = AW - MINLOG,
  localparam int SW    = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ctl_on,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_base,
  input  logic [SW-1:0] cfg_size,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_perm,
  input  logic          cfg_cache,
  input  logic          cfg_buf,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_kind,
  input  logic          acc_priv,
  output logic          acc_abort,
  output logic          acc_cache,
  output logic          acc_buf
);

  localparam logic [SW-1:0] SZ_TOP = SW'(MAXC);

  logic          unit_on;
  logic [AW-1:0] r_base [NREG];
  logic [SW-1:0] r_size [NREG];
  logic [1:0]    r_perm [NREG];
  logic [NREG-1:0] r_en, r_c, r_b;

  logic [SW-1:0] wr_size;
  assign wr_size = (cfg_size > SZ_TOP) ? SZ_TOP : cfg_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unit_on <= 1'b0;
    else if (ctl_we) unit_on <= ctl_on;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r_base[g] <= '0;
        r_size[g] <= '0;
        r_perm[g] <= '0;
        r_en[g]   <= 1'b0;
        r_c[g]    <= 1'b0;
        r_b[g]    <= 1'b0;
      end else if (cfg_we && cfg_idx == IW'(g)) begin
        r_base[g] <= cfg_base;
        r_size[g] <= wr_size;
        r_perm[g] <= cfg_perm;
        r_en[g]   <= cfg_en;
        r_c[g]    <= cfg_cache;
        r_b[g]    <= cfg_buf;
      end
    end
  end

  function automatic logic [AW-1:0] span_mask(input logic [SW-1:0] code);
    return {AW{1'b1}} << (int'(code) + MINLOG);
  endfunction

  logic          hit;
  logic [IW-1:0] win;
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = 0; i < NREG; i++)
      if (r_en[i] && ((acc_addr ^ r_base[i]) & span_mask(r_size[i])) == '0) begin
        hit = 1'b1;
        win = IW'(i);
      end
  end

  logic is_rd, allow, grant;
  assign is_rd = (acc_kind != 2'b01);

  always_comb begin
    case (r_perm[win])
      2'd0:    allow = 1'b0;
      2'd1:    allow = acc_priv;
      2'd2:    allow = acc_priv | is_rd;
      default: allow = 1'b1;
    endcase
  end

  assign grant     = unit_on & hit & allow;
  assign acc_abort = unit_on & ~(hit & allow);
  assign acc_cache = grant & r_c[win];
  assign acc_buf   = grant & r_b[win];

endmodule

module prot_region_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       unit_on,
  input logic       ctl_we,
  input logic       ctl_on,
  input logic       cfg_we,
  input logic [31:0] acc_addr,
  input logic [1:0] acc_kind,
  input logic       acc_priv,
  input logic       acc_abort,
  input logic       acc_cache,
  input logic       acc_buf
);

  a_r1_reset_clean: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !acc_abort && !acc_cache && !acc_buf);

  a_r2_off_allows: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_on |-> !acc_abort && !acc_cache && !acc_buf);

  a_r2_ctl_off_next: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_on) |=> !acc_abort);

  a_r7_abort_no_attr: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |-> !acc_cache && !acc_buf);

  a_r8_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !ctl_we) |=>
      (!($stable(acc_addr) && $stable(acc_kind) && $stable(acc_priv))
       || ($stable(acc_abort) && $stable(acc_cache) && $stable(acc_buf))));

endmodule

bind prot_region_unit prot_region_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .unit_on(unit_on), .ctl_we(ctl_we), .ctl_on(ctl_on),
  .cfg_we(cfg_we), .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_priv(acc_priv),
  .acc_abort(acc_abort), .acc_cache(acc_cache), .acc_buf(acc_buf)
);

// File: tb/prot_region_unit_tb.sv
module prot_region_unit_tb;
  logic clk = 0, rst_n = 0;
  logic ctl_we = 0, ctl_on = 0, cfg_we = 0;
  logic [2:0] cfg_idx = 0;
  logic [31:0] cfg_base = 0;
  logic [4:0] cfg_size = 0;
  logic cfg_en = 0, cfg_cache = 0, cfg_buf = 0;
  logic [1:0] cfg_perm = 0;
  logic [31:0] acc_addr = 0;
  logic [1:0] acc_kind = 0;
  logic acc_priv = 0;
  logic acc_abort, acc_cache, acc_buf;

  int n_run = 0, n_fail = 0;

  localparam logic [1:0] RD = 2'd0, WR = 2'd1, FE = 2'd2;

  always #2.5 clk = ~clk;

  prot_region_unit u_dut (.*);

  task automatic expect3(string tag, logic ab, logic c, logic b);
    n_run++;
    if ({acc_abort, acc_cache, acc_buf} !== {ab, c, b}) begin
      n_fail++;
      $display("FAIL %s addr=%h kind=%0d priv=%0d got abort/c/b=%b%b%b exp=%b%b%b",
               tag, acc_addr, acc_kind, acc_priv, acc_abort, acc_cache, acc_buf, ab, c, b);
    end
  endtask

  task automatic probe(string tag, logic [31:0] a, logic [1:0] k, logic p,
                       logic ab, logic c, logic b);
    @(negedge clk);
    acc_addr = a; acc_kind = k; acc_priv = p;
    #1 expect3(tag, ab, c, b);
  endtask

  task automatic wr_region(int idx, logic [31:0] base, logic [4:0] sz, logic en,
                           logic [1:0] perm, logic c, logic b);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_base = base; cfg_size = sz;
    cfg_en = en; cfg_perm = perm; cfg_cache = c; cfg_buf = b;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wr_ctl(logic on);
    @(negedge clk);
    ctl_we = 1; ctl_on = on;
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic t_reset();
    probe("R1 reset user write", 32'h0000_1000, WR, 0, 0, 0, 0);
    probe("R1 reset fetch", 32'hFFFF_FFFC, FE, 1, 0, 0, 0);
  endtask

  task automatic t_off();
    wr_region(0, 32'h0, 5'd20, 1, 2'd0, 1, 1);
    probe("R2 off ignores no-access region", 32'h0000_4000, WR, 0, 0, 0, 0);
    wr_region(0, 32'h0, 5'd0, 0, 2'd0, 0, 0);
  endtask

  task automatic t_miss();
    wr_ctl(1);
    probe("R4 on with no region", 32'h0000_4000, RD, 1, 1, 0, 0);
  endtask

  task automatic t_bounds();
    wr_region(1, 32'h0001_0000, 5'd4, 1, 2'd3, 1, 0);
    probe("R3 low edge", 32'h0001_0000, RD, 0, 0, 1, 0);
    probe("R3 high edge", 32'h0001_FFFC, WR, 0, 0, 1, 0);
    probe("R4 just above", 32'h0002_0000, RD, 1, 1, 0, 0);
    probe("R4 just below", 32'h0000_FFFC, RD, 1, 1, 0, 0);
    wr_region(1, 32'h0001_2345, 5'd4, 1, 2'd3, 1, 0);
    probe("R3 base low bits ignored", 32'h0001_0004, RD, 0, 0, 1, 0);
  endtask

  task automatic t_overlap();
    wr_region(5, 32'h0001_8000, 5'd3, 1, 2'd1, 0, 1);
    probe("R5 high index denies user", 32'h0001_8000, RD, 0, 1, 0, 0);
    probe("R5 high index attrs sup write", 32'h0001_8010, WR, 1, 0, 0, 1);
    probe("R5 lower part keeps region1", 32'h0001_7FFC, RD, 0, 0, 1, 0);
  endtask

  task automatic t_perms();
    wr_region(5, 32'h0001_8000, 5'd3, 1, 2'd2, 0, 1);
    probe("R6 code2 user read", 32'h0001_8000, RD, 0, 0, 0, 1);
    probe("R6 code2 user write", 32'h0001_8000, WR, 0, 1, 0, 0);
    probe("R6 code2 user fetch", 32'h0001_8000, FE, 0, 0, 0, 1);
    probe("R6 code2 sup write", 32'h0001_8000, WR, 1, 0, 0, 1);
    probe("R6 kind3 as read", 32'h0001_8000, 2'd3, 0, 0, 0, 1);
    wr_region(5, 32'h0001_8000, 5'd3, 1, 2'd0, 1, 1);
    probe("R6 code0 sup read", 32'h0001_8000, RD, 1, 1, 0, 0);
    probe("R7 abort clears attrs", 32'h0001_8000, FE, 1, 1, 0, 0);
  endtask

  task automatic t_disable_and_timing();
    @(negedge clk);
    acc_addr = 32'h0001_8000; acc_kind = WR; acc_priv = 0;
    cfg_we = 1; cfg_idx = 3'd5; cfg_base = 32'h0001_8000; cfg_size = 5'd3;
    cfg_en = 0; cfg_perm = 2'd0; cfg_cache = 0; cfg_buf = 0;
    #1 expect3("R8 before write edge", 1, 0, 0);
    @(negedge clk);
    cfg_we = 0;
    #1 expect3("R8 disabled region ignored after edge", 0, 1, 0);
    probe("R8 other region untouched", 32'h0001_0000, RD, 0, 0, 1, 0);
  endtask

  task automatic t_size_clamp();
    wr_region(0, 32'hDEAD_B000, 5'd31, 1, 2'd3, 0, 1);
    probe("R3 clamp to whole space", 32'hFFFF_F000, WR, 0, 0, 0, 1);
    probe("R5 region1 still wins over region0", 32'h0001_0000, WR, 0, 0, 1, 0);
    wr_region(0, 32'h0000_0000, 5'd0, 1, 2'd3, 1, 1);
    probe("R3 4KB top byte", 32'h0000_0FFF, RD, 0, 0, 1, 1);
    probe("R4 4KB next page", 32'h0000_1000, RD, 0, 1, 0, 0);
  endtask

  task automatic t_ctl_off_timing();
    @(negedge clk);
    acc_addr = 32'h0000_1000; acc_kind = RD; acc_priv = 0;
    ctl_we = 1; ctl_on = 0;
    #1 expect3("R8 ctl before edge", 1, 0, 0);
    @(negedge clk);
    ctl_we = 0;
    #1 expect3("R2 ctl off after edge", 0, 0, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_off();
        t_miss();
        t_bounds();
        t_overlap();
        t_perms();
        t_disable_and_timing();
        t_size_clamp();
        t_ctl_off_timing();
      end
      begin
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule